// File: doc/BRIEF.md
# Serial Command Receiver with Pass-Through Output

This block is the slave side of a four-wire serial link that carries fixed 16-bit command words. The master lowers the active-low select, presents bits on the data input most significant first, and pulses the serial clock. The receiver takes one bit on each rising serial-clock edge. The word is released to a downstream command decoder only when the select returns high, and only if exactly sixteen bits arrived. The decoder receives the word as opcode, address and data fields, together with a one-cycle valid strobe.

The serial output works like an open-drain pin. The block either pulls the line low or lets it float high. In normal use it repeats the input stream sixteen rising edges late, so several receivers can be chained from one master. When the previous accepted word was a readback request, the next frame instead shifts out a 16-bit word. That word holds zeros in its upper byte and, in its lower byte, the register byte that the decoder places on a parallel input.

The serial pins are brought into the block's own clock domain through a synchronizer of configurable depth, and every edge decision is taken in that domain.

Top module: `spi_cmd_frontend`

## Requirements
- R1: An accepted frame is split into three fields. The first bit received becomes bit 15 of the word. `cmd_opcode` takes word bits 15:12, `cmd_addr` takes bits 11:8 and `cmd_data` takes bits 7:0.
- R2: Data is taken only on rising edges of `spi_sclk` while `spi_cs_n` is low. A falling edge never captures a bit.
- R3: `cmd_valid` is high for exactly one clock cycle after each accepted frame, and only after `spi_cs_n` has risen. Outside that pulse the three command fields keep their last accepted values.
- R4: A frame whose rising-edge count is not 16 when `spi_cs_n` rises is discarded. This applies to short frames and to long frames. A discarded frame raises no strobe and leaves the command fields unchanged.
- R5: A falling edge of `spi_cs_n` clears the bit counter and the receive and transmit shift registers. Bits left over from an aborted frame therefore never reach a later word.
- R6: When the preceding accepted frame was not a readback, the line at rising edge k carries the input bit taken at rising edge k-16. It reads 0 for k of 16 or less.
- R7: After an accepted frame whose opcode is 4'h9 or 4'hA, the next frame shifts out {8'h00, rb_data} most significant bit first. `rb_data` is captured when that frame's select falls, and the first bit is valid before the first rising edge.
- R8: A readback request is served by exactly one following frame and then returns to pass-through. A discarded frame carrying a readback opcode requests nothing.
- R9: `sdo_pull_low` = 1 means the block pulls the line low (a 0 bit). It is never 1 while `spi_cs_n` is high, so the line is released between frames.
- R10: After reset `cmd_valid` is 0, the command fields are 0 and `sdo_pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in, most significant bit first |
| sdo_pull_low | output | 1 | 1 pulls the serial output line low, 0 releases it |
| cmd_valid | output | 1 | One-cycle strobe for an accepted word |
| cmd_opcode | output | 4 | Opcode field of the last accepted word |
| cmd_addr | output | 4 | Address field of the last accepted word |
| cmd_data | output | 8 | Data field of the last accepted word |
| rb_data | input | 8 | Register byte returned in a readback frame |

## Verification
The bench tries the receiver with five kinds of frame, and each one separates a different kind of fault:
- Words with distinct bit patterns at both ends (16'h8001, 16'h3A5C) catch reversed bit order and field slips.
- A 32-bit frame shows the sixteen-edge echo in its second half, and it also shows that an over-length frame is rejected.
- A 15-bit frame and a 12-bit frame, each followed by a good word, catch counters and shift registers that are not cleared when the select falls.
- Readback requests with both readback opcodes, followed by frames with other opcodes, show that the returned byte appears exactly once and that the block then goes back to the echo.
- The line is also read in idle gaps, to confirm that it is released there.

// File: rtl/spi_cmdfe_pkg.sv
package spi_cmdfe_pkg;
   localparam int unsigned DEF_OPC_W = 4;
   localparam int unsigned DEF_ADR_W = 4;
   localparam int unsigned DEF_DAT_W = 8;
   localparam int unsigned DEF_RB_A  = 9;
   localparam int unsigned DEF_RB_B  = 10;

   // Source of the next frame's outgoing bits
   typedef enum logic {
      TX_ECHO     = 1'b0,
      TX_READBACK = 1'b1
   } tx_src_e;
endpackage

// File: rtl/spi_cmdfe_sync.sv
module spi_cmdfe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_raw,
   input  logic cs_n_raw,
   input  logic sdi_raw,
   output logic sdi_s,
   output logic cs_low,
   output logic sclk_rise,
   output logic cs_fall,
   output logic cs_rise
);
   // bit 2: sclk, bit 1: cs_n, bit 0: sdi
   localparam logic [2:0] IDLE = 3'b010;

   logic [2:0] stage_out;
   logic       sclk_q;
   logic       cs_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign stage_out = {sclk_raw, cs_n_raw, sdi_raw};
      end else begin : g_chain
         logic [2:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
            end else begin
               pipe[0] <= {sclk_raw, cs_n_raw, sdi_raw};
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign stage_out = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= stage_out[2];
         cs_q   <= stage_out[1];
      end
   end

   assign sdi_s     = stage_out[0];
   assign cs_low    = ~stage_out[1];
   assign sclk_rise = stage_out[2] & ~sclk_q;
   assign cs_fall   = ~stage_out[1] & cs_q;
   assign cs_rise   = stage_out[1] & ~cs_q;
endmodule

// File: rtl/spi_cmdfe_rx.sv
module spi_cmdfe_rx #(
   parameter int unsigned OPC_W = 4,
   parameter int unsigned ADR_W = 4,
   parameter int unsigned DAT_W = 8,
   localparam int unsigned FRAME_W = OPC_W + ADR_W + DAT_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_rise,
   input  logic             cs_fall,
   input  logic             cs_rise,
   input  logic             cs_low,
   input  logic             sdi_s,
   output logic             accept,
   output logic [OPC_W-1:0] accept_opc,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             cmd_valid,
   output logic [OPC_W-1:0] cmd_opcode,
   output logic [ADR_W-1:0] cmd_addr,
   output logic [DAT_W-1:0] cmd_data
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   logic [FRAME_W-1:0] rx_sr;

   assign accept     = cs_rise & (bit_cnt == CNT_FULL);
   assign accept_opc = rx_sr[FRAME_W-1 -: OPC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr   <= '0;
         bit_cnt <= '0;
      end else if (cs_fall) begin
         rx_sr   <= '0;
         bit_cnt <= '0;
      end else if (sclk_rise && cs_low) begin
         rx_sr <= {rx_sr[FRAME_W-2:0], sdi_s};
         if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid  <= 1'b0;
         cmd_opcode <= '0;
         cmd_addr   <= '0;
         cmd_data   <= '0;
      end else begin
         cmd_valid <= accept;
         if (accept) begin
            cmd_opcode <= rx_sr[FRAME_W-1 -: OPC_W];
            cmd_addr   <= rx_sr[DAT_W +: ADR_W];
            cmd_data   <= rx_sr[DAT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/spi_cmdfe_tx.sv
module spi_cmdfe_tx
   import spi_cmdfe_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned DAT_W   = 8,
   parameter int unsigned RB_A    = 9,
   parameter int unsigned RB_B    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_rise,
   input  logic             cs_fall,
   input  logic             cs_low,
   input  logic             sdi_s,
   input  logic             accept,
   input  logic [OPC_W-1:0] accept_opc,
   input  logic [DAT_W-1:0] rb_data,
   output logic             sdo_pull_low
);
   localparam int unsigned PAD_W = FRAME_W - DAT_W;

   tx_src_e            next_src;
   logic [FRAME_W-1:0] tx_sr;
   logic               is_rb;

   assign is_rb = (accept_opc == OPC_W'(RB_A)) || (accept_opc == OPC_W'(RB_B));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_src <= TX_ECHO;
      end else if (cs_fall) begin
         next_src <= TX_ECHO;
      end else if (accept) begin
         next_src <= is_rb ? TX_READBACK : TX_ECHO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
      end else if (cs_fall) begin
         tx_sr <= (next_src == TX_READBACK) ? {{PAD_W{1'b0}}, rb_data} : '0;
      end else if (sclk_rise && cs_low) begin
         tx_sr <= {tx_sr[FRAME_W-2:0], sdi_s};
      end
   end

   assign sdo_pull_low = cs_low & ~tx_sr[FRAME_W-1];
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
   import spi_cmdfe_pkg::*;
#(
   parameter int unsigned OPC_W       = DEF_OPC_W,
   parameter int unsigned ADR_W       = DEF_ADR_W,
   parameter int unsigned DAT_W       = DEF_DAT_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RB_OPC_A    = DEF_RB_A,
   parameter int unsigned RB_OPC_B    = DEF_RB_B,
   localparam int unsigned FRAME_W = OPC_W + ADR_W + DAT_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sclk,
   input  logic             spi_cs_n,
   input  logic             spi_sdi,
   output logic             sdo_pull_low,
   output logic             cmd_valid,
   output logic [OPC_W-1:0] cmd_opcode,
   output logic [ADR_W-1:0] cmd_addr,
   output logic [DAT_W-1:0] cmd_data,
   input  logic [DAT_W-1:0] rb_data
);
   generate
      if (OPC_W < 1 || DAT_W < 1) begin : g_bad_fields
         $error("opcode and data fields need at least one bit");
      end
      if (FRAME_W < DAT_W + 1) begin : g_bad_pad
         $error("frame must be wider than the readback byte");
      end
      if (RB_OPC_A >= (1 << OPC_W) || RB_OPC_B >= (1 << OPC_W)) begin : g_bad_rb
         $error("readback opcodes must fit the opcode field");
      end
   endgenerate

   logic             sdi_s, cs_low, sclk_rise, cs_fall, cs_rise;
   logic             accept;
   logic [OPC_W-1:0] accept_opc;
   logic [CNT_W-1:0] bit_cnt;

   spi_cmdfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_raw(spi_sclk), .cs_n_raw(spi_cs_n), .sdi_raw(spi_sdi),
      .sdi_s(sdi_s), .cs_low(cs_low), .sclk_rise(sclk_rise),
      .cs_fall(cs_fall), .cs_rise(cs_rise)
   );

   spi_cmdfe_rx #(.OPC_W(OPC_W), .ADR_W(ADR_W), .DAT_W(DAT_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .cs_low(cs_low), .sdi_s(sdi_s),
      .accept(accept), .accept_opc(accept_opc), .bit_cnt(bit_cnt),
      .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   spi_cmdfe_tx #(
      .FRAME_W(FRAME_W), .OPC_W(OPC_W), .DAT_W(DAT_W),
      .RB_A(RB_OPC_A), .RB_B(RB_OPC_B)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_low(cs_low),
      .sdi_s(sdi_s), .accept(accept), .accept_opc(accept_opc),
      .rb_data(rb_data), .sdo_pull_low(sdo_pull_low)
   );
endmodule

// File: rtl/spi_cmdfe_chk.sv
module spi_cmdfe_chk #(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned ADR_W   = 4,
   parameter int unsigned DAT_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_rise,
   input logic             cs_fall,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             cmd_valid,
   input logic [OPC_W-1:0] cmd_opcode,
   input logic [ADR_W-1:0] cmd_addr,
   input logic [DAT_W-1:0] cmd_data
);
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   assert_strobe_after_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(cs_rise));

   assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> $stable({cmd_opcode, cmd_addr, cmd_data}));

   assert_no_strobe_bad_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && bit_cnt != CNT_W'(FRAME_W)) |=> !cmd_valid);

   assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));

   assert_clear_on_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (bit_cnt == '0));
endmodule

bind spi_cmd_frontend spi_cmdfe_chk #(
   .FRAME_W(FRAME_W), .CNT_W(CNT_W), .OPC_W(OPC_W), .ADR_W(ADR_W), .DAT_W(DAT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
   .bit_cnt(bit_cnt), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
   .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/spi_cmd_frontend_tb_top.sv
module spi_cmd_frontend_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sclk = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_sdi = 1'b0;
   logic       sdo_pull_low;
   logic       cmd_valid;
   logic [3:0] cmd_opcode;
   logic [3:0] cmd_addr;
   logic [7:0] cmd_data;
   logic [7:0] rb_data = 8'h00;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   int accepted = 0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];
   logic [15:0] last_ok = 16'h0000;

   always #10 clk = ~clk;

   spi_cmd_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_sdi(spi_sdi), .sdo_pull_low(sdo_pull_low), .cmd_valid(cmd_valid),
      .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rb_data(rb_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: every strobe must match the oldest expected word
   always @(negedge clk) begin
      if (rst_n && cmd_valid) begin
         strobes++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected strobe", {16'h0, cmd_opcode, cmd_addr, cmd_data}, 32'h0);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check({cmd_opcode, cmd_addr, cmd_data} == e, "R1 decoded fields",
                  {16'h0, cmd_opcode, cmd_addr, cmd_data}, {16'h0, e});
         end
      end
   end

   // Drives one frame of n bits and returns the line level seen before each rising edge
   task automatic frame(input logic [31:0] bits, input int n, output logic [31:0] line);
      line = '0;
      if (n == 16) begin
         exp_q.push_back(bits[15:0]);
         accepted++;
         last_ok = bits[15:0];
      end
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         spi_sdi = bits[n-1-i];
         repeat (4) @(negedge clk);
         line = {line[30:0], ~sdo_pull_low};
         spi_sclk = 1'b1;
         repeat (4) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic check_held(input string req);
      check({cmd_opcode, cmd_addr, cmd_data} == last_ok, req,
            {16'h0, cmd_opcode, cmd_addr, cmd_data}, {16'h0, last_ok});
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] ln;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(cmd_valid == 1'b0, "R10 strobe idle", {31'h0, cmd_valid}, 32'h0);
      check({cmd_opcode, cmd_addr, cmd_data} == 16'h0, "R10 fields zero",
            {16'h0, cmd_opcode, cmd_addr, cmd_data}, 32'h0);
      check(sdo_pull_low == 1'b0, "R10 line released", {31'h0, sdo_pull_low}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1/R6: first frame after reset echoes zeros
      frame(32'h3A5C, 16, ln);
      check(ln[15:0] == 16'h0000, "R6 echo of cleared register", ln, 32'h0);
      // R2: bit order and rising-edge capture
      frame(32'h8001, 16, ln);
      check(ln[15:0] == 16'h0000, "R2 R6 echo zeros", ln, 32'h0);
      check(sdo_pull_low == 1'b0, "R9 released between frames", {31'h0, sdo_pull_low}, 32'h0);

      // R4/R6: 32-bit frame, discarded, second half echoes first half
      frame(32'h1234ABCD, 32, ln);
      check(ln == 32'h00001234, "R6 sixteen-edge echo", ln, 32'h00001234);
      check_held("R4 long frame discarded");

      // R4/R5: short frame then good frame
      frame(32'h7FFF, 15, ln);
      check_held("R4 short frame discarded");
      frame(32'h5501, 16, ln);
      check(ln[15:0] == 16'h0000, "R5 transmit cleared", ln, 32'h0);

      // R7: readback with opcode 9
      rb_data = 8'hC3;
      frame(32'h9200, 16, ln);
      frame(32'h0000, 16, ln);
      check(ln[15:0] == 16'h00C3, "R7 readback opcode 9", ln, 32'h00C3);
      // R8: served once
      rb_data = 8'hFF;
      frame(32'h0100, 16, ln);
      check(ln[15:0] == 16'h0000, "R8 readback consumed", ln, 32'h0);

      // R7: readback with opcode A
      rb_data = 8'h5A;
      frame(32'hA011, 16, ln);
      frame(32'h7777, 16, ln);
      check(ln[15:0] == 16'h005A, "R7 readback opcode A", ln, 32'h005A);
      check(sdo_pull_low == 1'b0, "R9 released after readback", {31'h0, sdo_pull_low}, 32'h0);

      // R8: discarded frame with readback opcode requests nothing
      frame(32'h09FF, 12, ln);
      check_held("R4 12-bit frame discarded");
      frame(32'hC3E7, 16, ln);
      check(ln[15:0] == 16'h0000, "R8 no readback from discarded frame", ln, 32'h0);

      repeat (10) @(negedge clk);
      // R3: one strobe per accepted frame
      check(strobes == accepted, "R3 strobe count", strobes, accepted);
      check(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule